// File: doc/BRIEF.md
# Double-Buffered Audio Playback DMA

This block streams audio from system memory to a DAC. Every frame is one 16-bit left sample and one 16-bit right sample packed in a 32-bit word. The block has no local sample store. A programmable divider produces a frame strobe. Each strobe fetches one word from memory, puts the two samples on the DAC output and moves the read address forward by four bytes. The block does no mixing, scaling or format change on the samples.

Software first writes a start address, then writes a byte length. Writing the length queues the buffer. The block holds one playing buffer and one waiting buffer. The waiting buffer starts on the cycle after the playing one runs out, so the frame cadence has no gap. The interrupt pulses when a buffer starts playing, not when it ends. This gives software a full buffer's playtime to prepare the next one.

The current address is held as a 13-bit low part and a separate high part. The carry out of the low part reaches the high part one cycle late. With `LATE_CARRY=1`, a buffer whose final frame ends exactly on a 0x2000 boundary leaves that carry pending, and the next buffer then plays 0x2000 above its programmed start. With `LATE_CARRY=0`, the address is a plain counter.

Top module: `snd_dma_play`

## Requirements
- R1: After reset the block is idle. The status register (offset 0xC) reads 0. The length register reads 0. The rate register (offset 0x8) reads `DIV_RST`. `irq`, `mem_req` and `dac_valid` are low, and the staged start address is 0.
- R2: A write to offset 0x0 stages bits [23:0] of the data as the next start address. Bits [31:24] are dropped. The address cannot be read back: a read of offset 0x0 returns the same value as a read of offset 0x4.
- R3: A write to offset 0x4 queues a transfer of (data[17:0] with bits [1:0] cleared) bytes from the staged address. A length that is zero after masking is ignored. A read of offset 0x4 returns the bytes left in the playing transfer, or 0 when idle.
- R4: Offset 0x8 holds the divider N. Values below 1 count as 1. During a transfer, one frame is delivered every N+1 cycles.
- R5: For each frame, the word read from memory goes out with bits [31:16] on `dac_left` and bits [15:0] on `dac_right`, and `dac_valid` is high for one cycle. Frames follow ascending word addresses from the start of the buffer, and a transfer of L bytes delivers exactly L/4 frames.
- R6: A transfer queued while another plays starts on the cycle after the playing one ends, and the frame spacing stays N+1 cycles across the switch.
- R7: Status bit 0 reads 1 while a transfer plays. Status bit 1 reads 1 while a second transfer waits. A length write while both are set is ignored and plays nothing.
- R8: `irq` pulses for exactly one cycle each time a transfer starts. When the length write finds the block idle, the pulse comes in the cycle after the write. Queueing a buffer behind a playing one does not pulse `irq`.
- R9: `mem_req` stays high with `mem_addr` unchanged until `mem_ack` is seen.
- R10: With `LATE_CARRY=1`, if the previous transfer's end address (start plus length) is a multiple of 0x2000, the next transfer plays from its programmed address plus 0x2000, modulo 2^24. This applies whether the next transfer was queued or started later from idle.
- R11: With `LATE_CARRY=0`, every transfer plays from its programmed address.
- R12: A transfer that crosses a 0x2000 boundary in its middle continues at the next word address, with no skip and no repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (bits [3:2] decode) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mem_req | output | 1 | Frame fetch request |
| mem_addr | output | 24 | Byte address of the frame fetch |
| mem_ack | input | 1 | Fetch completes, `mem_rdata` valid |
| mem_rdata | input | 32 | Fetched frame word |
| dac_valid | output | 1 | One-cycle pulse for a new frame |
| dac_left | output | 16 | Left sample |
| dac_right | output | 16 | Right sample |
| irq | output | 1 | Pulse when a transfer starts |

## Verification
The bench goes after the cases where the address can drift:
- A buffer ending exactly on a 0x2000 boundary, followed by a queued buffer, a buffer started from idle, and a wrap past the top of the 24-bit space. A design that drops or misplaces the late carry plays the wrong samples, which the per-frame data pattern exposes.
- A buffer crossing a page in its middle. A carry applied too late or twice would repeat or skip a page.

The bench runs a bug-compatible instance and a corrected instance side by side, so the 0x2000 shift must appear in exactly one of them. It also exercises:
- A length write into a full queue. A design that accepted it would play extra frames.
- A length that masks to zero. A design that accepted it would pulse `irq`.
- Frame gaps across a buffer switch. A stall at the switch would stretch one gap.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;

    // register slot selected by reg_addr[3:2]
    typedef enum logic [1:0] {
        OFS_ADDR = 2'd0,
        OFS_LEN  = 2'd1,
        OFS_RATE = 2'd2,
        OFS_STAT = 2'd3
    } reg_ofs_e;

    // one stereo frame of two 16-bit samples
    localparam int FRAME_BYTES = 4;

endpackage

// File: rtl/snd_rate_gen.sv
module snd_rate_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = 1'b0;
        cnt_d  = cnt_q;
        if (cnt_q == '0) begin
            tick_o = 1'b1;
            // a divider of zero is treated as one: period never below two cycles
            cnt_d  = (div_i == '0) ? DIV_W'(1) : div_i;
        end else begin
            cnt_d = cnt_q - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/snd_split_addr.sv
module snd_split_addr #(
    parameter int ADDR_W     = 24,
    parameter int LOW_W      = 13,
    parameter int STEP       = 4,
    parameter bit LATE_CARRY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              step_i,
    input  logic              run_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              carry_o
);

    localparam int HIGH_W = ADDR_W - LOW_W;

    typedef struct packed {
        logic [HIGH_W-1:0] hi;
        logic [LOW_W-1:0]  lo;
        logic              cy;
    } ctr_t;

    ctr_t st_d, st_q;

    generate
        if (LATE_CARRY) begin : g_late
            logic [LOW_W:0] lo_sum;
            always_comb begin
                st_d   = st_q;
                lo_sum = {1'b0, st_q.lo} + (LOW_W + 1)'(STEP);
                if (load_i) begin
                    // a carry still owed from the last transfer lands on the new one
                    st_d.lo = load_addr_i[LOW_W-1:0];
                    st_d.hi = load_addr_i[ADDR_W-1:LOW_W] + HIGH_W'(st_q.cy);
                    st_d.cy = 1'b0;
                end else if (step_i) begin
                    st_d.lo = lo_sum[LOW_W-1:0];
                    st_d.hi = st_q.hi + HIGH_W'(st_q.cy);
                    st_d.cy = lo_sum[LOW_W];
                end else if (run_i) begin
                    st_d.hi = st_q.hi + HIGH_W'(st_q.cy);
                    st_d.cy = 1'b0;
                end
            end
        end else begin : g_direct
            logic [ADDR_W-1:0] nxt;
            always_comb begin
                st_d = st_q;
                nxt  = {st_q.hi, st_q.lo} + ADDR_W'(STEP);
                if (load_i) begin
                    {st_d.hi, st_d.lo} = load_addr_i;
                end else if (step_i) begin
                    {st_d.hi, st_d.lo} = nxt;
                end
                st_d.cy = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o  = {st_q.hi, st_q.lo};
    assign carry_o = st_q.cy;

endmodule

// File: rtl/snd_dma_play.sv
module snd_dma_play
    import snd_dma_pkg::*;
#(
    parameter int              ADDR_W     = 24,
    parameter int              LOW_W      = 13,
    parameter int              LEN_W      = 18,
    parameter int              DIV_W      = 16,
    parameter logic [DIV_W-1:0] DIV_RST   = 16'd16,
    parameter bit              LATE_CARRY = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [23:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        dac_valid,
    output logic [15:0] dac_left,
    output logic [15:0] dac_right,
    output logic        irq
);

    typedef struct packed {
        logic              busy;
        logic [LEN_W-1:0]  rem;
        logic              pend_ok;
        logic [ADDR_W-1:0] pend_addr;
        logic [LEN_W-1:0]  pend_len;
        logic [ADDR_W-1:0] stage_addr;
        logic [DIV_W-1:0]  div;
        logic              req;
        logic              out_vld;
        logic [15:0]       out_l;
        logic [15:0]       out_r;
        logic              irq;
    } ctl_t;

    ctl_t d, q;

    logic              tick;
    logic              ld;
    logic [ADDR_W-1:0] ld_addr;
    logic              step;
    logic              run;
    logic [ADDR_W-1:0] cur_addr;
    logic              carry_w;
    logic              busy_w;
    logic              full_w;
    logic              rem_zero_w;
    logic              cur_free;
    logic              fire;
    logic              took;
    logic [LEN_W-1:0]  wr_len;
    reg_ofs_e          ofs;
    logic              unused_bits;

    assign unused_bits = ^{reg_addr[1:0], reg_wdata};

    snd_rate_gen #(
        .DIV_W (DIV_W)
    ) i_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (q.div),
        .tick_o (tick)
    );

    snd_split_addr #(
        .ADDR_W     (ADDR_W),
        .LOW_W      (LOW_W),
        .STEP       (FRAME_BYTES),
        .LATE_CARRY (LATE_CARRY)
    ) i_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (ld),
        .load_addr_i (ld_addr),
        .step_i      (step),
        .run_i       (run),
        .addr_o      (cur_addr),
        .carry_o     (carry_w)
    );

    assign ofs        = reg_ofs_e'(reg_addr[3:2]);
    assign busy_w     = q.busy;
    assign full_w     = q.pend_ok;
    assign rem_zero_w = (q.rem == '0);
    assign wr_len     = {reg_wdata[LEN_W-1:2], 2'b00};
    // the playing slot frees this cycle when it has run out and nothing waits
    assign cur_free   = !q.busy || (rem_zero_w && !q.pend_ok);
    assign run        = q.busy && !rem_zero_w;
    // hold the fetch while a low-half carry is still on its way to the high half
    assign fire       = q.req && q.busy && !rem_zero_w && !carry_w;
    assign took       = fire && mem_ack;

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        d.out_vld = 1'b0;
        ld        = 1'b0;
        ld_addr   = q.pend_addr;
        step      = 1'b0;

        // frame pacing and fetch
        if (tick && q.busy) d.req = 1'b1;
        else if (took)      d.req = 1'b0;

        if (took) begin
            d.out_l   = mem_rdata[31:16];
            d.out_r   = mem_rdata[15:0];
            d.out_vld = 1'b1;
            d.rem     = q.rem - LEN_W'(FRAME_BYTES);
            step      = 1'b1;
        end

        // end of the playing transfer: switch to the waiting one or go idle
        if (q.busy && rem_zero_w) begin
            if (q.pend_ok) begin
                ld        = 1'b1;
                ld_addr   = q.pend_addr;
                d.rem     = q.pend_len;
                d.pend_ok = 1'b0;
                d.irq     = 1'b1;
            end else begin
                d.busy = 1'b0;
                d.req  = 1'b0;
            end
        end

        if (reg_wr) begin
            unique case (ofs)
                OFS_ADDR: d.stage_addr = reg_wdata[ADDR_W-1:0];
                OFS_LEN: begin
                    if (wr_len != '0) begin
                        if (cur_free) begin
                            ld      = 1'b1;
                            ld_addr = q.stage_addr;
                            d.busy  = 1'b1;
                            d.rem   = wr_len;
                            d.irq   = 1'b1;
                        end else if (!q.pend_ok) begin
                            d.pend_ok   = 1'b1;
                            d.pend_addr = q.stage_addr;
                            d.pend_len  = wr_len;
                        end
                    end
                end
                OFS_RATE: d.div = reg_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.div <= DIV_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_ADDR, OFS_LEN: reg_rdata = 32'(q.rem);
            OFS_RATE:          reg_rdata = 32'(q.div);
            default:           reg_rdata = {30'b0, full_w, busy_w};
        endcase
    end

    assign mem_req   = fire;
    assign mem_addr  = cur_addr;
    assign dac_valid = q.out_vld;
    assign dac_left  = q.out_l;
    assign dac_right = q.out_r;
    assign irq       = q.irq;

endmodule

// File: rtl/snd_dma_play_chk.sv
module snd_dma_play_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [3:0]        reg_addr,
    input logic              irq,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dac_valid,
    input logic              busy_w,
    input logic              full_w,
    input logic              rem_zero_w
);

    assert_dac_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

    assert_frame_from_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> $past(mem_req && mem_ack));

    assert_switch_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w && rem_zero_w && full_w |=> irq);

    assert_full_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full_w && !rem_zero_w && reg_wr && (reg_addr[3:2] == 2'd1) |=> full_w);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy_w && !rem_zero_w);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

endmodule

bind snd_dma_play snd_dma_play_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .irq        (irq),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .dac_valid  (dac_valid),
    .busy_w     (busy_w),
    .full_w     (full_w),
    .rem_zero_w (rem_zero_w)
);

// File: tb/test_snd_dma_play.sv
module test_snd_dma_play;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata [2];
    logic        mem_req [2];
    logic [23:0] mem_addr [2];
    logic        mem_ack [2];
    logic [31:0] mem_rdata [2];
    logic        dac_valid [2];
    logic [15:0] dac_left [2];
    logic [15:0] dac_right [2];
    logic        irq [2];

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // accepted transfers, in play order
    logic [23:0] tr_addr [256];
    int          tr_len [256];
    int          n_tr = 0;

    // per-instance expectation state (0: late carry, 1: corrected)
    int          exp_idx [2] = '{0, 0};
    int          exp_off [2] = '{0, 0};
    logic [23:0] exp_base [2];
    bit          prev_b [2] = '{0, 0};
    string       tag_now [2];
    int          irq_cnt [2] = '{0, 0};

    bit          slow_mem = 1'b0;
    bit          seen [2] = '{0, 0};
    logic [23:0] held [2];

    bit          gap_en = 1'b0;
    int          gap_p = 0;
    int          last_v = -1;
    string       gap_tag = "R6";
    logic        irq_after_wr;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    snd_dma_play #(.LATE_CARRY(1'b1)) i_snd_dma_play (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata[0]), .mem_req(mem_req[0]),
        .mem_addr(mem_addr[0]), .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0]),
        .dac_valid(dac_valid[0]), .dac_left(dac_left[0]), .dac_right(dac_right[0]),
        .irq(irq[0]));

    snd_dma_play #(.LATE_CARRY(1'b0)) i_snd_dma_play_fix (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata[1]), .mem_req(mem_req[1]),
        .mem_addr(mem_addr[1]), .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1]),
        .dac_valid(dac_valid[1]), .dac_left(dac_left[1]), .dac_right(dac_right[1]),
        .irq(irq[1]));

    function automatic logic [31:0] pat(input logic [23:0] a);
        return {a[17:2] ^ 16'h5A5A, a[23:8]};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin
        mem_ack[0] = 1'b0; mem_ack[1] = 1'b0;
        mem_rdata[0] = '0; mem_rdata[1] = '0;
    end

    // memory model: answers at the falling edge, optionally one cycle late
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (mem_req[i]) begin
                if (slow_mem && !seen[i]) begin
                    seen[i]    = 1'b1;
                    held[i]    = mem_addr[i];
                    mem_ack[i] = 1'b0;
                end else begin
                    if (seen[i])
                        chk(held[i] == mem_addr[i], "R9", "address moved while waiting",
                            32'(mem_addr[i]), 32'(held[i]));
                    mem_ack[i]   = 1'b1;
                    mem_rdata[i] = pat(mem_addr[i]);
                    seen[i]      = 1'b0;
                end
            end else begin
                mem_ack[i] = 1'b0;
                seen[i]    = 1'b0;
            end
        end
    end

    // frame monitor
    always @(negedge clk) begin
        logic [23:0] a;
        string       tg;
        for (int i = 0; i < 2; i++) begin
            if (irq[i]) irq_cnt[i]++;
            if (dac_valid[i]) begin
                if (exp_idx[i] >= n_tr) begin
                    chk(1'b0, "R7", "frame beyond accepted transfers", 32'(exp_idx[i]), 32'(n_tr));
                end else begin
                    if (exp_off[i] == 0) begin
                        exp_base[i] = tr_addr[exp_idx[i]] + ((i == 0 && prev_b[i]) ? 24'h2000 : 24'h0);
                        tag_now[i]  = (i == 0 && prev_b[i]) ? "R10" :
                                      ((i == 1 && prev_b[i]) ? "R11" : "R5");
                    end
                    a  = exp_base[i] + 24'(exp_off[i]);
                    tg = (exp_off[i] != 0 && a[12:0] == 13'h0) ? "R12" : tag_now[i];
                    chk({dac_left[i], dac_right[i]} == pat(a), tg,
                        $sformatf("frame data inst%0d", i), {dac_left[i], dac_right[i]}, pat(a));
                    exp_off[i] += 4;
                    if (exp_off[i] == tr_len[exp_idx[i]]) begin
                        a          = exp_base[i] + 24'(exp_off[i]);
                        prev_b[i]  = (a[12:0] == 13'h0);
                        exp_idx[i]++;
                        exp_off[i] = 0;
                    end
                end
            end
        end
        if (dac_valid[0] && gap_en) begin
            if (last_v >= 0)
                chk(cyc - last_v == gap_p, gap_tag, "frame spacing", 32'(cyc - last_v), 32'(gap_p));
            last_v = cyc;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] dat);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = dat;
        @(posedge clk);
        #1 irq_after_wr = irq[0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] dat);
        reg_addr = a;
        #1 dat = rdata[0];
    endtask

    task automatic push(input logic [23:0] a, input int len);
        tr_addr[n_tr] = a;
        tr_len[n_tr]  = len;
        n_tr++;
    endtask

    task automatic wait_idle;
        forever begin
            @(negedge clk);
            reg_addr = 4'hC;
            #1;
            if (rdata[0] == 0 && rdata[1] == 0) break;
        end
    endtask

    task automatic play(input logic [23:0] a, input int len);
        wr(4'h0, 32'(a));
        wr(4'h4, len);
        push(a, len);
    endtask

    task automatic run_all;
        logic [31:0] v, v2;
        logic [23:0] ad;
        int          len;

        // reset state
        repeat (5) @(negedge clk);
        rd(4'hC, v); chk(v == 0, "R1", "status in reset", v, 0);
        rd(4'h4, v); chk(v == 0, "R1", "length in reset", v, 0);
        rd(4'h8, v); chk(v == 16, "R1", "rate default", v, 16);
        chk(!mem_req[0] && !irq[0] && !dac_valid[0], "R1", "outputs in reset",
            {mem_req[0], irq[0], dac_valid[0]}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req[0] && !irq[0], "R1", "quiet after reset", {mem_req[0], irq[0]}, 0);

        // divider, staged address, masked length
        wr(4'h8, 3);
        rd(4'h8, v); chk(v == 3, "R4", "rate readback", v, 3);
        wr(4'h0, 32'hFF00_1000);
        rd(4'h0, v); chk(v == 0, "R2", "address not readable while idle", v, 0);
        gap_en = 1'b1; gap_p = 4; gap_tag = "R6"; last_v = -1;
        wr(4'h4, 32'h13);
        chk(irq_after_wr == 1'b1, "R8", "irq after length write from idle", irq_after_wr, 1);
        push(24'h001000, 16);
        rd(4'h0, v); rd(4'h4, v2);
        chk(v2 == 16, "R3", "masked length", v2, 16);
        chk(v == v2, "R2", "offset 0 mirrors offset 4", v, v2);

        // queue a second buffer, then overfill
        wr(4'h0, 32'h002000);
        wr(4'h4, 32'h10);
        chk(irq_after_wr == 1'b0, "R8", "no irq on queueing", irq_after_wr, 0);
        push(24'h002000, 16);
        rd(4'hC, v); chk(v == 3, "R7", "status busy and full", v, 3);
        wr(4'h0, 32'h030000);
        wr(4'h4, 32'h20);
        rd(4'hC, v); chk(v == 3, "R7", "status after ignored write", v, 3);
        wait_idle();
        gap_en = 1'b0;
        chk(exp_idx[0] == n_tr, "R6", "both buffers played", 32'(exp_idx[0]), 32'(n_tr));
        chk(irq_cnt[0] == n_tr, "R8", "one irq per start", 32'(irq_cnt[0]), 32'(n_tr));

        // zero length after masking
        wr(4'h4, 32'h3);
        chk(irq_after_wr == 1'b0, "R3", "zero length no irq", irq_after_wr, 0);
        rd(4'hC, v); chk(v == 0, "R3", "zero length stays idle", v, 0);

        // end on a page boundary, next queued
        play(24'h001FF0, 16);
        play(24'h004000, 8);
        wait_idle();
        // page crossing mid-transfer
        play(24'h003FF8, 16);
        wait_idle();
        // end on boundary, then start from idle
        play(24'h00BFF8, 8);
        wait_idle();
        repeat (10) @(negedge clk);
        play(24'h010000, 8);
        wait_idle();
        // end at the top of the address space
        play(24'hFFFFF8, 8);
        wait_idle();
        play(24'h000100, 4);
        wait_idle();

        // rate within one buffer
        wr(4'h8, 6);
        gap_en = 1'b1; gap_p = 7; gap_tag = "R4"; last_v = -1;
        play(24'h020000, 24);
        wait_idle();
        gap_en = 1'b0;

        // random buffers, each queued once the previous has started
        wr(4'h8, $urandom_range(5, 2));
        slow_mem = 1'b1;
        for (int k = 0; k < 24; k++) begin
            len = 4 * (1 + $urandom_range(11, 0));
            if ($urandom_range(2, 0) == 0) ad = 24'($urandom_range(2047, 1) << 13) - 24'(len);
            else ad = 24'($urandom) & 24'hFFFFFC;
            while (irq_cnt[0] < n_tr) @(negedge clk);
            play(ad, len);
        end
        wait_idle();
        slow_mem = 1'b0;
        for (int i = 0; i < 2; i++) begin
            chk(exp_idx[i] == n_tr, "R5", $sformatf("all frames inst%0d", i), 32'(exp_idx[i]), 32'(n_tr));
            chk(irq_cnt[i] == n_tr, "R8", $sformatf("irq count inst%0d", i), 32'(irq_cnt[i]), 32'(n_tr));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule